// File: doc/BRIEF.md
# MAC Product Conditioner

This block is the multiply stage that sits in front of a 48-bit multiply-accumulate adder. Each accepted request carries two 32-bit operands and a mode: signed integer, unsigned integer or signed fractional. The block forms the full 64-bit product and conditions it so the accumulator stage can add it directly.

In the two integer modes the product is limited to 40 significant bits. When the product does not fit, the block reports an overflow. If overflow-mode-control is set, it replaces the product with a value large enough that the following accumulate is sure to overflow too. In fractional mode the product is scaled down by 2^24 and can be rounded to nearest, with ties going to even. A final optional one-bit left or right shift is applied. The overflow indication is merged into a caller-supplied overflow status bit by OR, so this stage can set that bit but never clear it.

The stage is a single register with a two-state controller. EMPTY means no result is held and LOADED means a result is presented. The LOAD transition, taken from either state, happens on any cycle with `in_valid` high. The DRAIN transition, also from either state, happens on any cycle with `in_valid` low and returns the controller to EMPTY.

Top module: `mac_prod_cond`

## Requirements
- R1: After reset `out_valid` is 0, `product` is 0 and `v_out` is 0.
- R2: A request sampled with `in_valid` high at a rising edge is presented with `out_valid` high after that edge. `out_valid` is low after any edge at which `in_valid` was low.
- R3: Encoding `mode` 2'b00 (signed integer) gives the two's-complement product of the operands whenever that product fits in 40 signed bits. Encoding 2'b11 behaves exactly like 2'b00.
- R4: In signed integer mode, a product that differs from its own low 40 bits sign-extended is an overflow. With `omc` = 0 the output is those low 40 bits sign-extended to 64 bits.
- R5: On signed overflow with `omc` = 1, the output is 2^50 if the product is non-negative and the bitwise inverse of 2^50 if the product is negative.
- R6: In `mode` 2'b01 (unsigned), any set bit in product bits 63..40 is an overflow. On overflow the output is 2^50 when `omc` = 1, and otherwise the product truncated to its low 40 bits. Without overflow the output is the product.
- R7: In `mode` 2'b10 (fractional), the signed product is shifted right arithmetically by 24 bits. With `round_en` = 0 nothing is added.
- R8: In fractional mode with `round_en` = 1, the discarded 24-bit field causes the shifted value to be incremented in two cases: when the field exceeds 0x800000, or when it equals 0x800000 and the shifted value is odd.
- R9: `shift_sel` 2'b01 shifts the conditioned value left by one bit and 2'b10 shifts it right arithmetically by one bit. Both 2'b00 and 2'b11 leave the value unchanged.
- R10: `v_out` is `v_in` ORed with the overflow of the request. Fractional mode never produces an overflow.
- R11: While `in_valid` is low, `product` and `v_out` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op_a | input | 32 | First multiplicand |
| op_b | input | 32 | Second multiplicand |
| mode | input | 2 | 00 signed int, 01 unsigned, 10 fractional, 11 signed int |
| omc | input | 1 | Overflow-mode-control: force a certain-overflow value |
| round_en | input | 1 | Round-to-nearest-even in fractional mode |
| shift_sel | input | 2 | 00 none, 01 left by one, 10 right by one, 11 none |
| v_in | input | 1 | Current overflow status bit |
| out_valid | output | 1 | Result register holds a fresh result |
| product | output | 64 | Conditioned product for the accumulator |
| v_out | output | 1 | Updated overflow status bit |

## Verification
The properties assume that every control and data input is a known value whenever `in_valid` is high. They also assume that `v_in` describes the status bit at the moment the request is accepted. The bench changes all inputs only on falling edges, so every input is already settled at the rising edge where it is sampled. Between requests it drops `in_valid` for at least one cycle, which exercises both the LOAD and DRAIN transitions. The signed-range and unsigned-range properties are only claimed when no post-shift is selected, and the bench covers the shifted cases with separate directed requests.

// File: rtl/mac_cond_pkg.sv
package mac_cond_pkg;

    typedef enum logic [1:0] {
        MODE_SINT = 2'b00,
        MODE_UINT = 2'b01,
        MODE_FRAC = 2'b10,
        MODE_ALT  = 2'b11
    } mul_mode_e;

    typedef enum logic [1:0] {
        SH_NONE  = 2'b00,
        SH_LEFT  = 2'b01,
        SH_RIGHT = 2'b10,
        SH_KEEP  = 2'b11
    } shift_e;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } stage_state_e;

endpackage

// File: rtl/mac_mul_core.sv
// Full-width multiplier; one array serves signed and unsigned operands by
// extending each operand to the product width before multiplying.
module mac_mul_core #(
    parameter int OP_W = 32
) (
    input  logic [OP_W-1:0]   a,
    input  logic [OP_W-1:0]   b,
    input  logic              is_signed,
    output logic [2*OP_W-1:0] prod
);
    localparam int PROD_W = 2 * OP_W;

    logic [PROD_W-1:0] a_ext;
    logic [PROD_W-1:0] b_ext;
    logic              a_fill;
    logic              b_fill;

    always_comb begin
        a_fill = is_signed & a[OP_W-1];
        b_fill = is_signed & b[OP_W-1];
        a_ext  = {{OP_W{a_fill}}, a};
        b_ext  = {{OP_W{b_fill}}, b};
        prod   = a_ext * b_ext;
    end
endmodule

// File: rtl/mac_int_limiter.sv
// Integer range check: keeps KEEP_W significant bits, flags overflow and
// optionally substitutes a forced value that the accumulate cannot absorb.
module mac_int_limiter #(
    parameter int PROD_W    = 64,
    parameter int KEEP_W    = 40,
    parameter int FORCE_BIT = 50
) (
    input  logic [PROD_W-1:0] prod,
    input  logic              is_signed,
    input  logic              omc,
    output logic [PROD_W-1:0] dout,
    output logic              ovf
);
    localparam int HI_W = PROD_W - KEEP_W;
    localparam logic [PROD_W-1:0] FORCE_POS = {{(PROD_W-1){1'b0}}, 1'b1} << FORCE_BIT;
    localparam logic [PROD_W-1:0] FORCE_NEG = ~FORCE_POS;

    logic [PROD_W-1:0] sext_low;
    logic [PROD_W-1:0] zext_low;
    logic              ovf_s;
    logic              ovf_u;

    always_comb begin
        sext_low = {{HI_W{prod[KEEP_W-1]}}, prod[KEEP_W-1:0]};
        zext_low = {{HI_W{1'b0}}, prod[KEEP_W-1:0]};
        ovf_s    = (sext_low != prod);
        ovf_u    = |prod[PROD_W-1:KEEP_W];
    end

    always_comb begin
        if (is_signed) begin
            ovf = ovf_s;
            if (!ovf_s) begin
                dout = prod;
            end else if (omc) begin
                dout = prod[PROD_W-1] ? FORCE_NEG : FORCE_POS;
            end else begin
                dout = sext_low;
            end
        end else begin
            ovf = ovf_u;
            if (!ovf_u) begin
                dout = prod;
            end else if (omc) begin
                dout = FORCE_POS;
            end else begin
                dout = zext_low;
            end
        end
    end
endmodule

// File: rtl/mac_frac_scaler.sv
// Fractional scaling: arithmetic right shift by FRAC_SH with optional
// round-to-nearest, ties to even, on the discarded field.
module mac_frac_scaler #(
    parameter int PROD_W  = 64,
    parameter int FRAC_SH = 24
) (
    input  logic [PROD_W-1:0] prod,
    input  logic              round_en,
    output logic [PROD_W-1:0] dout
);
    localparam logic [FRAC_SH-1:0] HALF = {1'b1, {(FRAC_SH-1){1'b0}}};

    logic signed [PROD_W-1:0] scaled;
    logic [FRAC_SH-1:0]       dropped;
    logic                     above_half;
    logic                     at_half;
    logic                     bump;

    always_comb begin
        scaled     = $signed(prod) >>> FRAC_SH;
        dropped    = prod[FRAC_SH-1:0];
        above_half = (dropped > HALF);
        at_half    = (dropped == HALF);
        bump       = round_en & (above_half | (at_half & scaled[0]));
        dout       = PROD_W'(scaled) + {{(PROD_W-1){1'b0}}, bump};
    end
endmodule

// File: rtl/mac_shift1.sv
// One-bit post shift; the fill bit for a right shift is chosen by parameter.
module mac_shift1
    import mac_cond_pkg::*;
#(
    parameter int W           = 64,
    parameter bit RIGHT_ARITH = 1'b1
) (
    input  logic [W-1:0] din,
    input  logic [1:0]   sel,
    output logic [W-1:0] dout
);
    logic fill;

    generate
        if (RIGHT_ARITH) begin : g_arith
            assign fill = din[W-1];
        end else begin : g_logic
            assign fill = 1'b0;
        end
    endgenerate

    always_comb begin
        unique case (shift_e'(sel))
            SH_LEFT:  dout = {din[W-2:0], 1'b0};
            SH_RIGHT: dout = {fill, din[W-1:1]};
            SH_NONE:  dout = din;
            SH_KEEP:  dout = din;
            default:  dout = din;
        endcase
    end
endmodule

// File: rtl/mac_prod_cond.sv
// Registered multiply-and-condition stage feeding a 48-bit accumulator.
module mac_prod_cond
    import mac_cond_pkg::*;
#(
    parameter int OP_W      = 32,
    parameter int KEEP_W    = 40,
    parameter int FRAC_SH   = 24,
    parameter int FORCE_BIT = 50
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [OP_W-1:0]      op_a,
    input  logic [OP_W-1:0]      op_b,
    input  logic [1:0]           mode,
    input  logic                 omc,
    input  logic                 round_en,
    input  logic [1:0]           shift_sel,
    input  logic                 v_in,
    output logic                 out_valid,
    output logic [2*OP_W-1:0]    product,
    output logic                 v_out
);
    localparam int PROD_W = 2 * OP_W;

    mul_mode_e         mode_e;
    logic              mul_signed;
    logic              is_frac;
    logic [PROD_W-1:0] raw_prod;
    logic [PROD_W-1:0] int_val;
    logic              int_ovf;
    logic [PROD_W-1:0] frac_val;
    logic [PROD_W-1:0] cond_val;
    logic              cond_ovf;
    logic [PROD_W-1:0] final_val;

    stage_state_e      state_q;
    stage_state_e      state_d;
    logic [PROD_W-1:0] prod_q;
    logic              v_q;

    // Operating mode decode: only unsigned mode multiplies without sign.
    always_comb begin
        mode_e = mul_mode_e'(mode);
        unique case (mode_e)
            MODE_UINT: begin
                mul_signed = 1'b0;
                is_frac    = 1'b0;
            end
            MODE_FRAC: begin
                mul_signed = 1'b1;
                is_frac    = 1'b1;
            end
            MODE_SINT, MODE_ALT: begin
                mul_signed = 1'b1;
                is_frac    = 1'b0;
            end
            default: begin
                mul_signed = 1'b1;
                is_frac    = 1'b0;
            end
        endcase
    end

    mac_mul_core #(
        .OP_W (OP_W)
    ) u_mul (
        .a         (op_a),
        .b         (op_b),
        .is_signed (mul_signed),
        .prod      (raw_prod)
    );

    mac_int_limiter #(
        .PROD_W    (PROD_W),
        .KEEP_W    (KEEP_W),
        .FORCE_BIT (FORCE_BIT)
    ) u_lim (
        .prod      (raw_prod),
        .is_signed (mul_signed),
        .omc       (omc),
        .dout      (int_val),
        .ovf       (int_ovf)
    );

    mac_frac_scaler #(
        .PROD_W  (PROD_W),
        .FRAC_SH (FRAC_SH)
    ) u_frac (
        .prod     (raw_prod),
        .round_en (round_en),
        .dout     (frac_val)
    );

    // Path select: fractional results never report overflow.
    always_comb begin
        if (is_frac) begin
            cond_val = frac_val;
            cond_ovf = 1'b0;
        end else begin
            cond_val = int_val;
            cond_ovf = int_ovf;
        end
    end

    mac_shift1 #(
        .W           (PROD_W),
        .RIGHT_ARITH (1'b1)
    ) u_shift (
        .din  (cond_val),
        .sel  (shift_sel),
        .dout (final_val)
    );

    // Stage controller: next-state logic.
    always_comb begin
        unique case (state_q)
            ST_EMPTY:  state_d = in_valid ? ST_LOADED : ST_EMPTY;
            ST_LOADED: state_d = in_valid ? ST_LOADED : ST_EMPTY;
            default:   state_d = ST_EMPTY;
        endcase
    end

    // Stage controller: state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: captured only on LOAD, held otherwise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_q <= '0;
            v_q    <= 1'b0;
        end else if (state_d == ST_LOADED) begin
            prod_q <= final_val;
            v_q    <= v_in | cond_ovf;
        end
    end

    assign out_valid = (state_q == ST_LOADED);
    assign product   = prod_q;
    assign v_out     = v_q;

endmodule

// File: rtl/mac_prod_cond_chk.sv
module mac_prod_cond_chk #(
    parameter int OP_W      = 32,
    parameter int KEEP_W    = 40,
    parameter int FORCE_BIT = 50
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        mode,
    input logic              omc,
    input logic [1:0]        shift_sel,
    input logic              v_in,
    input logic              out_valid,
    input logic [2*OP_W-1:0] product,
    input logic              v_out
);
    localparam int PROD_W = 2 * OP_W;
    localparam logic [PROD_W-1:0] FPOS = {{(PROD_W-1){1'b0}}, 1'b1} << FORCE_BIT;

    logic sgn_mode;
    logic in_range_s;
    logic hi_clear;
    assign sgn_mode   = (mode == 2'b00) || (mode == 2'b11);
    assign in_range_s = (product == {{(PROD_W-KEEP_W){product[KEEP_W-1]}}, product[KEEP_W-1:0]});
    assign hi_clear   = (product[PROD_W-1:KEEP_W] == '0);

    // R1
    always_comb begin
        if (!rst_n) begin
            p_reset_r1: assert (out_valid == 1'b0);
        end
    end

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_signed_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sgn_mode && shift_sel == 2'b00)
        |=> (in_range_s || product == FPOS || product == ~FPOS));

    p_unsigned_trunc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b01 && !omc && shift_sel == 2'b00) |=> hi_clear);

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && v_in) |=> v_out);

    p_frac_no_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b10 && !v_in) |=> !v_out);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(product) && $stable(v_out)));

endmodule

bind mac_prod_cond mac_prod_cond_chk #(
    .OP_W      (OP_W),
    .KEEP_W    (KEEP_W),
    .FORCE_BIT (FORCE_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .omc       (omc),
    .shift_sel (shift_sel),
    .v_in      (v_in),
    .out_valid (out_valid),
    .product   (product),
    .v_out     (v_out)
);

// File: tb/mac_prod_cond_tb.sv
module mac_prod_cond_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [1:0]  mode = '0;
    logic        omc = 1'b0;
    logic        round_en = 1'b0;
    logic [1:0]  shift_sel = '0;
    logic        v_in = 1'b0;
    logic        out_valid;
    logic [63:0] product;
    logic        v_out;

    int total = 0;
    int bad = 0;

    localparam logic [63:0] F50 = 64'h0004_0000_0000_0000;

    always #10 clk = ~clk;

    mac_prod_cond u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .mode(mode), .omc(omc), .round_en(round_en), .shift_sel(shift_sel),
        .v_in(v_in), .out_valid(out_valid), .product(product), .v_out(v_out)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Independent reference built from R3..R9; returns {overflow, value}.
    function automatic logic [64:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [1:0] m, input logic o,
                                          input logic r, input logic [1:0] sh);
        longint      sp;
        longint      s40;
        longint      q;
        logic [63:0] up;
        logic [63:0] v;
        logic        ov;
        logic [23:0] low;
        ov = 1'b0;
        sp = longint'(signed'(a)) * longint'(signed'(b));
        if (m == 2'b01) begin
            up = {32'd0, a} * {32'd0, b};
            ov = (up >> 40) != 0;
            if (ov) v = o ? F50 : (up & 64'h0000_00FF_FFFF_FFFF);
            else    v = up;
        end else if (m == 2'b10) begin
            q   = sp >>> 24;
            low = sp[23:0];
            if (r && (low > 24'h800000 || (low == 24'h800000 && q[0]))) q = q + 1;
            v = q;
        end else begin
            s40 = (sp <<< 24) >>> 24;
            ov  = (s40 != sp);
            if (!ov)    v = sp;
            else if (o) v = (sp < 0) ? ~F50 : F50;
            else        v = s40;
        end
        if (sh == 2'b01)      v = v << 1;
        else if (sh == 2'b10) v = {v[63], v[63:1]};
        return {ov, v};
    endfunction

    // Sends one request and leaves the result on the outputs at the next falling edge.
    task automatic send(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m,
                        input logic o, input logic r, input logic [1:0] sh, input logic vi);
        @(negedge clk);
        op_a = a; op_b = b; mode = m; omc = o; round_en = r; shift_sel = sh; v_in = vi;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run(input string req, input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] m, input logic o, input logic r, input logic [1:0] sh,
                       input logic vi, input logic [63:0] exp_val, input logic exp_v);
        logic [64:0] ref_v;
        send(a, b, m, o, r, sh, vi);
        ref_v = model(a, b, m, o, r, sh);
        check({req, " value"}, product, exp_val);
        check({req, " model"}, product, ref_v[63:0]);
        check({req, " v_out"}, {63'd0, v_out}, {63'd0, exp_v});
        check({req, " valid R2"}, {63'd0, out_valid}, 64'd1);
    endtask

    task automatic t_reset;
        check("R1 out_valid", {63'd0, out_valid}, 64'd0);
        check("R1 product", product, 64'd0);
        check("R1 v_out", {63'd0, v_out}, 64'd0);
    endtask

    task automatic t_signed;
        run("R3 small", 32'd1000, -32'sd3, 2'b00, 0, 0, 2'b00, 0, 64'hFFFF_FFFF_FFFF_F448, 0);
        run("R3 alt mode", -32'sd3, 32'd5, 2'b11, 0, 0, 2'b00, 0, 64'hFFFF_FFFF_FFFF_FFF1, 0);
        run("R4 wrap", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'b00, 0, 0, 2'b00, 0, 64'hFFFF_FFFF_0000_0001, 1);
        run("R5 force pos", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'b00, 1, 0, 2'b00, 0, F50, 1);
        run("R5 force neg", 32'h8000_0000, 32'h7FFF_FFFF, 2'b00, 1, 0, 2'b00, 0, ~F50, 1);
    endtask

    task automatic t_unsigned;
        run("R6 fits", 32'h0001_0000, 32'h0001_0000, 2'b01, 1, 0, 2'b00, 0, 64'h0000_0001_0000_0000, 0);
        run("R6 trunc", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b01, 0, 0, 2'b00, 0, 64'h0000_00FE_0000_0001, 1);
        run("R6 force", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b01, 1, 0, 2'b00, 0, F50, 1);
    endtask

    task automatic t_frac;
        run("R7 scale", 32'h4000_0000, 32'h4000_0000, 2'b10, 1, 0, 2'b00, 0, 64'h0000_0010_0000_0000, 0);
        run("R7 no round", 32'd1, 32'h00C0_0000, 2'b10, 0, 0, 2'b00, 0, 64'd0, 0);
        run("R8 above half", 32'd1, 32'h00C0_0000, 2'b10, 0, 1, 2'b00, 0, 64'd1, 0);
        run("R8 tie even", 32'd1, 32'h0080_0000, 2'b10, 0, 1, 2'b00, 0, 64'd0, 0);
        run("R8 tie odd", 32'd1, 32'h0180_0000, 2'b10, 0, 1, 2'b00, 0, 64'd2, 0);
        run("R8 tie negative", 32'hFFFF_FFFF, 32'h0080_0000, 2'b10, 0, 1, 2'b00, 0, 64'd0, 0);
    endtask

    task automatic t_shift;
        run("R9 left", -32'sd6, 32'd7, 2'b00, 0, 0, 2'b01, 0, 64'hFFFF_FFFF_FFFF_FFAC, 0);
        run("R9 right", -32'sd6, 32'd7, 2'b00, 0, 0, 2'b10, 0, 64'hFFFF_FFFF_FFFF_FFEB, 0);
        run("R9 keep", -32'sd6, 32'd7, 2'b00, 0, 0, 2'b11, 0, 64'hFFFF_FFFF_FFFF_FFD6, 0);
    endtask

    task automatic t_sticky;
        run("R10 sticky", 32'd2, 32'd3, 2'b00, 0, 0, 2'b00, 1, 64'd6, 1);
        run("R10 frac clean", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'b10, 1, 0, 2'b00, 0,
            64'h0000_003F_FFFF_FF00, 0);
    endtask

    task automatic t_hold;
        send(32'd9, 32'd9, 2'b00, 0, 0, 2'b00, 1);
        op_a = 32'd5; op_b = 32'd5; v_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 product hold", product, 64'd81);
        check("R11 v hold", {63'd0, v_out}, 64'd1);
        check("R2 drained", {63'd0, out_valid}, 64'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_signed();
        t_unsigned();
        t_frac();
        t_shift();
        t_sticky();
        t_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule